// File: doc/BRIEF.md
# PLL Divider Search Engine

This block searches for the divider settings of a fractional-free PLL whose output is `refclk × (N+1) / ((M+1) × 2^K)`. Here M is the 4-bit input divider, N is the 9-bit feedback divider and K is the 2-bit post-divider exponent. A start pulse captures a reference frequency, a pixel clock, a parallel data-line count and a serial lane count. The engine first derives the target PLL frequency from the pixel clock and the two counts. It then places the target in one of four octave bands below 1 GHz, which fixes K.

Next it walks every (M, N) pair. It keeps the pair whose output lies inside the chosen band and comes closest to the target. The walk ends at once if a pair lands exactly on the target. Division is done with one shared shift-subtract divider. It runs once for the target and once per input-divider value. Within one input-divider value, consecutive feedback values are then handled by adding a precomputed quotient and remainder step, which takes one cycle per candidate.

Results are the three divider fields, the achieved frequency, the serial bit clock at half that frequency, the byte clock, and two 16-bit words packed in the layout of the PLL control registers. A check-only mode runs the same search and reports only pass or fail.

Top module: `pll_div_search`

## Requirements
- R1: The target frequency is floor(pclk_hz × data_lines / lanes). It is computed from the input values captured on the cycle that start is accepted.
- R2: A target of at least 1,000,000,000 or below 62,500,000 ends the run with err=1. Done comes exactly 40 cycles after the accepting edge, and the stored results stay unchanged.
- R3: K is the band index. K=0 covers [500 MHz, 1 GHz), K=1 covers [250, 500) MHz, K=2 covers [125, 250) MHz and K=3 covers [62.5, 125) MHz. A lower limit belongs to its own band. A candidate floor(refclk × (N+1) / ((M+1) << K)) is accepted only if it is at least the lower limit and strictly below the upper limit.
- R4: M runs 0..15 in the outer loop and N runs 0..511 in the inner loop. The best candidate is replaced only on a strictly smaller absolute difference from the target, so on a tie the earliest candidate wins.
- R5: An accepted candidate equal to the target ends the search. Done then comes 79 + 550×M + N cycles after the accepting edge. A search that never hits the target exactly takes 8840 cycles.
- R6: If no candidate inside the band is accepted, the run ends with err=1 and the stored results stay unchanged.
- R7: After a passing normal run, prd_o, fbd_o, frs_o and pll_hz hold the best candidate. dsi_hz is pll_hz/2 and byte_hz is pll_hz/8, both rounded down.
- R8: ctl0 carries M in bits 15:12 and N in bits 8:0, with all other bits zero.
- R9: ctl1 carries K in bits 11:10, the value 2'b10 in bits 9:8, and ones in bits 1 and 0, with all other bits zero.
- R10: busy is high from the accepting edge until done. done is a one-cycle pulse in the cycle that busy falls. A start pulse while busy is ignored.
- R11: Inputs that change during a run have no effect on that run's result.
- R12: With verify_only set at start, err reports pass or fail, and all result outputs keep their previous values.
- R13: After reset, busy, done, err and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| verify_only | input | 1 | Check-only run that leaves results unchanged |
| refclk_hz | input | 32 | Reference frequency in Hz |
| pclk_hz | input | 32 | Pixel clock in Hz |
| data_lines | input | 6 | Parallel data-line count |
| lanes | input | 3 | Serial lane count |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run failed |
| prd_o | output | 4 | Chosen input divider |
| fbd_o | output | 9 | Chosen feedback divider |
| frs_o | output | 2 | Chosen post-divider exponent |
| pll_hz | output | 32 | Achieved PLL frequency |
| dsi_hz | output | 32 | Serial bit clock, pll_hz/2 |
| byte_hz | output | 32 | Byte clock, dsi_hz/4 |
| ctl0 | output | 16 | Packed divider word |
| ctl1 | output | 16 | Packed range/enable word |

## Verification
Every result is due in the single cycle that done pulses. That cycle has a fixed place for each kind of run: 40 cycles for an out-of-band target, 79 + 550×M + N for an exact hit, and 8840 for a full walk. The bench computes the cycle count from the same reference search that yields the expected dividers. It counts falling edges from the accepting edge, samples on falling edges, and checks both the latency and every output in that cycle. On the cycle after done, it confirms that done has dropped and that the outputs still hold.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW = 32,
  parameter int LW = 6,
  parameter int NW = 3,
  parameter int PRD_W = 4,
  parameter int FBD_W = 9,
  parameter int BANDS = 4,
  parameter logic [FW-1:0] TOP_HZ = 32'd1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             verify_only,
  input  logic [FW-1:0]    refclk_hz,
  input  logic [FW-1:0]    pclk_hz,
  input  logic [LW-1:0]    data_lines,
  input  logic [NW-1:0]    lanes,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [PRD_W-1:0] prd_o,
  output logic [FBD_W-1:0] fbd_o,
  output logic [$clog2(BANDS)-1:0] frs_o,
  output logic [FW-1:0]    pll_hz,
  output logic [FW-1:0]    dsi_hz,
  output logic [FW-1:0]    byte_hz,
  output logic [15:0]      ctl0,
  output logic [15:0]      ctl1
);
  localparam int FRS_W = $clog2(BANDS);
  localparam int TW = FW + LW;
  localparam int DW = PRD_W + BANDS;
  localparam int QW = FW + FBD_W;
  localparam int CW = $clog2(TW + 1);

  typedef enum logic [2:0] {S_IDLE, S_TDIV, S_BAND, S_PDIV, S_SWEEP, S_FIN} state_t;
  state_t state;

  logic [FW-1:0]    ref_q;
  logic             vfy, have, valid;
  logic [TW-1:0]    tgt, dq;
  logic [DW-1:0]    drem, dden, r, rs;
  logic [CW-1:0]    dcnt;
  logic [FRS_W-1:0] frs;
  logic [PRD_W-1:0] prd, best_prd;
  logic [FBD_W-1:0] fbd, best_fbd;
  logic [QW-1:0]    q, qs;
  logic [FW-1:0]    best_pll, best_diff;

  // shift-subtract divider step
  logic [DW:0]   dsh;
  logic          dge;
  logic [TW-1:0] dq_n;
  logic [DW-1:0] drem_n;
  assign dsh    = {drem, dq[TW-1]};
  assign dge    = dsh >= {1'b0, dden};
  assign dq_n   = {dq[TW-2:0], dge};
  assign drem_n = dge ? DW'(dsh - {1'b0, dden}) : dsh[DW-1:0];

  // band selection on the target
  logic [FRS_W-1:0] sel;
  logic inband;
  always_comb begin
    sel = '0;
    for (int i = BANDS; i >= 1; i--)
      if (dq >= TW'(TOP_HZ >> i)) sel = FRS_W'(i - 1);
  end
  assign inband = dq < TW'(TOP_HZ) && dq >= TW'(TOP_HZ >> BANDS);

  // candidate evaluation
  logic [FW-1:0] lo, hi;
  logic [QW-1:0] diff;
  logic [DW:0]   r2;
  logic acc, take, exact, r_ge;
  assign lo    = TOP_HZ >> (int'(frs) + 1);
  assign hi    = TOP_HZ >> frs;
  assign acc   = q >= QW'(lo) && q < QW'(hi);
  assign diff  = q > QW'(tgt) ? q - QW'(tgt) : QW'(tgt) - q;
  assign take  = acc && (!have || diff[FW-1:0] < best_diff);
  assign exact = take && diff == '0;
  assign r2    = {1'b0, r} + {1'b0, rs};
  assign r_ge  = r2 >= {1'b0, dden};

  assign busy    = state != S_IDLE;
  assign dsi_hz  = pll_hz >> 1;
  assign byte_hz = pll_hz >> 3;
  assign ctl0    = (16'(prd_o) << 12) | 16'(fbd_o);
  assign ctl1    = valid ? ((16'(frs_o) << 10) | 16'h0203) : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {ref_q, vfy, have, valid, tgt, dq, drem, dden, r, rs, dcnt} <= '0;
      {frs, prd, fbd, q, qs, best_prd, best_fbd, best_pll, best_diff} <= '0;
      {done, err, prd_o, fbd_o, frs_o, pll_hz} <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ref_q <= refclk_hz;
          vfy   <= verify_only;
          have  <= 1'b0;
          dq    <= TW'(pclk_hz) * TW'(data_lines);
          drem  <= '0;
          dden  <= DW'(lanes);
          dcnt  <= '0;
          state <= S_TDIV;
        end
        S_TDIV, S_PDIV: begin
          dq   <= dq_n;
          drem <= drem_n;
          dcnt <= dcnt + 1'b1;
          if (dcnt == CW'(TW - 1)) begin
            if (state == S_TDIV) state <= S_BAND;
            else begin
              qs    <= QW'(dq_n);
              q     <= QW'(dq_n);
              rs    <= drem_n;
              r     <= drem_n;
              fbd   <= '0;
              state <= S_SWEEP;
            end
          end
        end
        S_BAND: if (!inband) state <= S_FIN;
        else begin
          tgt   <= dq;
          frs   <= sel;
          prd   <= '0;
          dq    <= TW'(ref_q);
          drem  <= '0;
          dden  <= DW'(1) << sel;
          dcnt  <= '0;
          state <= S_PDIV;
        end
        S_SWEEP: begin
          if (take) begin
            have      <= 1'b1;
            best_prd  <= prd;
            best_fbd  <= fbd;
            best_pll  <= q[FW-1:0];
            best_diff <= diff[FW-1:0];
          end
          if (exact || (fbd == '1 && prd == '1)) state <= S_FIN;
          else if (fbd == '1) begin
            prd   <= prd + 1'b1;
            dq    <= TW'(ref_q);
            drem  <= '0;
            dden  <= (DW'(prd) + DW'(2)) << frs;
            dcnt  <= '0;
            state <= S_PDIV;
          end else begin
            fbd <= fbd + 1'b1;
            q   <= q + qs + QW'(r_ge);
            r   <= r_ge ? DW'(r2 - {1'b0, dden}) : r2[DW-1:0];
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          err   <= !have;
          state <= S_IDLE;
          if (have && !vfy) begin
            prd_o  <= best_prd;
            fbd_o  <= best_fbd;
            frs_o  <= frs;
            pll_hz <= best_pll;
            valid  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int FW = 32,
  parameter int FRS_W = 2,
  parameter logic [FW-1:0] TOP_HZ = 32'd1000000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [FRS_W-1:0] frs_o,
  input logic [FW-1:0]    pll_hz,
  input logic [15:0]      ctl0,
  input logic [15:0]      ctl1
);
  a_r10_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  a_r3_result_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    pll_hz != '0 |-> (pll_hz < (TOP_HZ >> frs_o)) && (pll_hz >= (TOP_HZ >> (int'(frs_o) + 1))));
  a_r12_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pll_hz) && $stable(ctl0) && $stable(ctl1));
endmodule

bind pll_div_search pll_div_search_chk #(.FW(FW), .FRS_W(FRS_W), .TOP_HZ(TOP_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .frs_o(frs_o), .pll_hz(pll_hz), .ctl0(ctl0), .ctl1(ctl1));

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verify_only = 1'b0;
  logic [31:0] refclk_hz = '0, pclk_hz = '0;
  logic [5:0] data_lines = '0;
  logic [2:0] lanes = '0;
  logic busy, done, err;
  logic [3:0] prd_o;
  logic [8:0] fbd_o;
  logic [1:0] frs_o;
  logic [31:0] pll_hz, dsi_hz, byte_hz;
  logic [15:0] ctl0, ctl1;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pll_div_search u_pll_div_search (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned rf, pc, ln, la,
      output bit ok, output int p, output int f, output int fr,
      output longint unsigned pll, output int lat);
    longint unsigned tg, hi, lo, v, d, bd;
    bit have = 0;
    tg = pc * ln / la;
    ok = 0; p = 0; f = 0; fr = 0; pll = 0; lat = 40; bd = 0;
    if (tg >= 64'd1000000000 || tg < 64'd62500000) return;
    for (int i = 4; i >= 1; i--) if (tg >= (64'd1000000000 >> i)) fr = i - 1;
    hi = 64'd1000000000 >> fr;
    lo = 64'd1000000000 >> (fr + 1);
    lat = 8840;
    for (int pp = 0; pp < 16; pp++)
      for (int ff = 0; ff < 512; ff++) begin
        v = rf * longint'(ff + 1) / (longint'(pp + 1) << fr);
        if (v >= lo && v < hi) begin
          d = v > tg ? v - tg : tg - v;
          if (!have || d < bd) begin
            have = 1; bd = d; p = pp; f = ff; pll = v;
            if (d == 0) begin
              ok = 1; lat = 79 + 550 * pp + ff;
              return;
            end
          end
        end
      end
    ok = have;
  endfunction

  task automatic run(input longint unsigned rf, pc, ln, la, input bit vf, input bit poke);
    bit ok; int p, f, fr, lat, k;
    longint unsigned pll;
    logic [31:0] s_pll; logic [15:0] s_c0, s_c1;
    s_pll = pll_hz; s_c0 = ctl0; s_c1 = ctl1;
    model(rf, pc, ln, la, ok, p, f, fr, pll, lat);
    @(negedge clk);
    refclk_hz = 32'(rf); pclk_hz = 32'(pc); data_lines = 6'(ln); lanes = 3'(la);
    verify_only = vf; start = 1'b1;
    @(negedge clk);
    start = 1'b0; k = 0;
    chk("R10 busy after start", longint'(busy), 1);
    while (!done && k < 9000) begin
      @(negedge clk); k++;
      if (poke && k == 5) begin
        start = 1'b1; refclk_hz = 32'd7777777; pclk_hz = 32'd99000000; lanes = 3'd2;
      end else if (poke && k == 6) start = 1'b0;
    end
    chk("R5/R2 done latency", k, lat);
    chk("R6/R3 err flag", longint'(err), longint'(!ok));
    chk("R10 busy low at done", longint'(busy), 0);
    if (ok && !vf) begin
      chk("R4 prd", prd_o, p);
      chk("R4 fbd", fbd_o, f);
      chk("R3 frs", frs_o, fr);
      chk("R7 pll", pll_hz, longint'(pll));
      chk("R7 dsi", dsi_hz, longint'(pll / 2));
      chk("R7 byte", byte_hz, longint'(pll / 8));
      chk("R8 ctl0", ctl0, (p << 12) | f);
      chk("R9 ctl1", ctl1, (fr << 10) | 32'h203);
    end else begin
      chk("R12 pll held", pll_hz, s_pll);
      chk("R12 ctl0 held", ctl0, s_c0);
      chk("R12 ctl1 held", ctl1, s_c1);
    end
    @(negedge clk);
    chk("R10 done one cycle", longint'(done), 0);
  endtask

  initial begin
    #(4 * 195000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R13 busy reset", busy, 0);
    chk("R13 done reset", done, 0);
    chk("R13 err reset", err, 0);
    chk("R13 pll reset", pll_hz, 0);
    chk("R13 ctl1 reset", ctl1, 0);
    rst_n = 1'b1;
    // R1 R3 exact hit at the lower band edge
    run(25000000, 125000000, 16, 4, 0, 0);
    // R12 verify-only pass keeps results
    run(10000000, 62500000, 1, 1, 1, 0);
    // R3 62.5 MHz lower edge, exact
    run(10000000, 62500000, 1, 1, 0, 0);
    // R2 top limit and below bottom
    run(25000000, 250000000, 16, 4, 0, 0);
    run(25000000, 62499999, 1, 1, 0, 0);
    // R6 nothing reaches the band
    run(1000, 500000000, 1, 1, 0, 0);
    // R11 inputs and start changed mid-run
    run(19200000, 74250000, 24, 4, 0, 1);
    // R4 non-exact full walk
    run(27000000, 33333333, 24, 3, 0, 0);
    for (int n = 0; n < 7; n++) begin
      longint unsigned rf, pc, ln, la;
      rf = longint'($urandom_range(50000000, 10000000));
      pc = longint'($urandom_range(150000000, 20000000));
      ln = (n % 3 == 0) ? 16 : (n % 3 == 1) ? 18 : 24;
      la = longint'($urandom_range(4, 1));
      run(rf, pc, ln, la, n == 3, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule